// File: doc/BRIEF.md
# PS/2 Host Transmit Controller

This block sends a single byte from a host to a PS/2 keyboard or mouse. Both lines are open-drain: the block only ever pulls a line low through an output-enable, and the pad cell releases the line to its pull-up otherwise. A transfer begins when a start strobe arrives while the block is idle. The byte is captured and the clock line is held low to request a send. The data line is pulled low shortly before the clock is let go. The block then follows the falling edges of the clock that the device generates, presenting one frame bit after each edge. The frame is eight data bits with the least significant first, an odd parity bit and a released stop bit. On the eleventh falling edge the block samples the device's line-control acknowledge.

The request-to-send hold and every internal wait are counted in reference ticks, which are single-cycle enables at a nominal 8 MHz. The device clock is followed edge by edge, so no bit rate is assumed. A programmable tick limit aborts a transfer when the device stops clocking. The outcome is reported through a busy flag, a one-cycle done pulse, and held acknowledge and error flags.

Top module: `ps2_host_tx`

## Requirements
- R1: While reset is active, and whenever no transfer is in progress, both output-enables are 0 (lines released) and busy_o is 0.
- R2: A start_i pulse while idle sets busy_o and drives ps2_clk_oe_o to 1 for exactly RTS_TICKS reference ticks. With 8 MHz ticks and the default of 512, this is a 64 us hold, which is above the 60 us minimum.
- R3: ps2_data_oe_o goes to 1 (start bit 0) exactly DATA_LEAD ticks before ps2_clk_oe_o returns to 0, and it stays at 1 after the clock is released.
- R4: After falling edges 1 to 8 of the synchronized device clock, the block presents data bits 0 to 7 in that order, where line low means 0 and data_oe = ~bit. After edge 9 it presents odd parity, so the data bits and the parity bit together hold an odd number of ones. After edge 10 it releases the data line as the stop bit.
- R5: On falling edge 11, a synchronized data line that is low sets ack_ok_o=1 and err_o=0. A line that is high sets err_o=1 and ack_ok_o=0.
- R6: A start_i pulse while busy_o is 1 is ignored. The frame in flight is unchanged and only one done pulse follows.
- R7: If no falling edge arrives within timeout_i ticks in the shift phase, the transfer ends with err_o=1 and a done pulse, and both lines are released.
- R8: Falling clock edges seen within GUARD_TICKS ticks after the clock is released are not counted as frame edges.
- R9: done_o is a one-cycle pulse issued in the cycle busy_o falls. ack_ok_o and err_o hold their value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick enable (nominal 8 MHz) |
| start_i | input | 1 | Start strobe, one cycle |
| data_i | input | 8 | Byte to send, captured on start |
| timeout_i | input | TO_W | Shift-phase tick limit between device clock edges |
| ps2_clk_i | input | 1 | Clock pad input |
| ps2_data_i | input | 1 | Data pad input |
| ps2_clk_oe_o | output | 1 | 1 pulls the clock line low |
| ps2_data_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ack_ok_o | output | 1 | Last transfer acknowledged by the device |
| err_o | output | 1 | Last transfer missed its acknowledge or timed out |

## Verification
The bench builds the block with RTS_TICKS=32, DATA_LEAD=4, GUARD_TICKS=8, TO_W=8, and it ties tick_i high. With these values the request hold, the data lead and the guard window can be counted exactly in clock cycles, and a full frame takes a few hundred cycles. A timeout of 60 ticks is set well above the device model's falling-edge spacing of 12 cycles, so the timeout case only occurs when the model stops clocking. The short guard window makes it possible to inject a spurious clock pulse right after release and check that it is ignored.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RTS,
    ST_GUARD,
    ST_SHIFT
  } tx_state_e;

  localparam int unsigned FRAME_BITS = 10;  // data, parity, stop
  localparam int unsigned LAST_EDGE  = 10;  // edge index that samples line control
endpackage

// File: rtl/ps2_sync.sv
module ps2_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= async_i[g];
        sync_q <= meta_q;
      end
    end
    assign sync_o[g] = sync_q;
  end
endmodule

// File: rtl/ps2_tick_cnt.sv
module ps2_tick_cnt #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
  import ps2_tx_pkg::*;
#(
  parameter int unsigned RTS_TICKS   = 512,
  parameter int unsigned DATA_LEAD   = 8,
  parameter int unsigned GUARD_TICKS = 8,
  parameter int unsigned TO_W        = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            start_i,
  input  logic [7:0]      data_i,
  input  logic [TO_W-1:0] timeout_i,
  input  logic            ps2_clk_i,
  input  logic            ps2_data_i,
  output logic            ps2_clk_oe_o,
  output logic            ps2_data_oe_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            ack_ok_o,
  output logic            err_o
);
  localparam int unsigned PH_MAX = (RTS_TICKS > GUARD_TICKS) ? RTS_TICKS : GUARD_TICKS;
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] RTS_END   = PH_W'(RTS_TICKS - 1);
  localparam logic [PH_W-1:0] LEAD_AT   = PH_W'(RTS_TICKS - DATA_LEAD - 1);
  localparam logic [PH_W-1:0] GUARD_END = PH_W'(GUARD_TICKS - 1);
  localparam logic [TO_W:0]   TO_ONE    = (TO_W + 1)'(1);

  tx_state_e state_q, state_d;
  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [3:0] edge_q, edge_d;
  logic clk_oe_q, clk_oe_d, data_oe_q, data_oe_d;
  logic done_q, done_d, ack_q, ack_d, err_q, err_d;

  logic [1:0] pad_s;
  logic clk_s, data_s, clk_prev_q, clk_fall;
  logic [PH_W-1:0] ph_cnt;
  logic [TO_W-1:0] to_cnt;
  logic ph_clr, to_clr, to_hit;

  ps2_sync #(.W(2)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ps2_data_i, ps2_clk_i}),
    .sync_o  (pad_s)
  );
  assign clk_s  = pad_s[0];
  assign data_s = pad_s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_prev_q <= 1'b1;
    else         clk_prev_q <= clk_s;
  end
  assign clk_fall = clk_prev_q & ~clk_s;

  ps2_tick_cnt #(.W(PH_W)) i_ph_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ph_clr),
    .tick_i (tick_i),
    .cnt_o  (ph_cnt)
  );

  ps2_tick_cnt #(.W(TO_W)) i_to_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (to_clr),
    .tick_i (tick_i),
    .cnt_o  (to_cnt)
  );

  assign to_clr = (state_q != ST_SHIFT) | clk_fall;
  assign to_hit = tick_i & (({1'b0, to_cnt} + TO_ONE) >= {1'b0, timeout_i});

  always_comb begin
    state_d   = state_q;
    frame_d   = frame_q;
    edge_d    = edge_q;
    clk_oe_d  = clk_oe_q;
    data_oe_d = data_oe_q;
    done_d    = 1'b0;
    ack_d     = ack_q;
    err_d     = err_q;
    ph_clr    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ph_clr = 1'b1;
        if (start_i) begin
          frame_d  = {1'b1, ~^data_i, data_i};
          clk_oe_d = 1'b1;
          ack_d    = 1'b0;
          err_d    = 1'b0;
          state_d  = ST_RTS;
        end
      end
      ST_RTS: begin
        if (tick_i && ph_cnt == LEAD_AT) data_oe_d = 1'b1;  // data low leads clock release
        if (tick_i && ph_cnt == RTS_END) begin
          clk_oe_d = 1'b0;
          ph_clr   = 1'b1;
          state_d  = ST_GUARD;
        end
      end
      ST_GUARD: begin
        if (tick_i && ph_cnt == GUARD_END) begin
          edge_d  = '0;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (clk_fall) begin
          edge_d = edge_q + 1'b1;
          if (edge_q == 4'(LAST_EDGE)) begin
            ack_d     = ~data_s;
            err_d     = data_s;
            done_d    = 1'b1;
            data_oe_d = 1'b0;
            state_d   = ST_IDLE;
          end else begin
            data_oe_d = ~frame_q[edge_q];
          end
        end else if (to_hit) begin
          err_d     = 1'b1;
          ack_d     = 1'b0;
          done_d    = 1'b1;
          data_oe_d = 1'b0;
          clk_oe_d  = 1'b0;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      frame_q   <= '0;
      edge_q    <= '0;
      clk_oe_q  <= 1'b0;
      data_oe_q <= 1'b0;
      done_q    <= 1'b0;
      ack_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      frame_q   <= frame_d;
      edge_q    <= edge_d;
      clk_oe_q  <= clk_oe_d;
      data_oe_q <= data_oe_d;
      done_q    <= done_d;
      ack_q     <= ack_d;
      err_q     <= err_d;
    end
  end

  assign ps2_clk_oe_o  = clk_oe_q;
  assign ps2_data_oe_o = data_oe_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign ack_ok_o      = ack_q;
  assign err_o         = err_q;
endmodule

// File: rtl/ps2_host_tx_chk.sv
module ps2_host_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ps2_clk_oe_o,
  input logic ps2_data_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic ack_ok_o,
  input logic err_o
);
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ps2_clk_oe_o && !ps2_data_oe_o)); // R1
  AST_CLK_HOLD_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ps2_clk_oe_o) |-> $past(!busy_o && start_i)); // R2
  AST_DATA_LEADS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ps2_clk_oe_o) && busy_o) |-> ps2_data_oe_o); // R3
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_ok_o && err_o)); // R5
  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R9
  AST_STATUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o && !start_i) |=> ($stable(ack_ok_o) && $stable(err_o))); // R9
endmodule

bind ps2_host_tx ps2_host_tx_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .ps2_clk_oe_o  (ps2_clk_oe_o),
  .ps2_data_oe_o (ps2_data_oe_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .ack_ok_o      (ack_ok_o),
  .err_o         (err_o)
);

// File: tb/test_ps2_host_tx.sv
module test_ps2_host_tx;
  localparam int CLK_PERIOD = 10;
  localparam int RTS   = 32;
  localparam int LEAD  = 4;
  localparam int GUARD = 8;
  localparam int TOW   = 8;
  localparam int HALF  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] din = '0;
  logic [TOW-1:0] tmo = TOW'(60);
  logic dev_clk = 1'b1, dev_data = 1'b1;
  logic clk_oe, data_oe, busy, done, ack_ok, err;
  logic clk_line, data_line;

  assign clk_line  = clk_oe  ? 1'b0 : dev_clk;
  assign data_line = data_oe ? 1'b0 : dev_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_host_tx #(.RTS_TICKS(RTS), .DATA_LEAD(LEAD), .GUARD_TICKS(GUARD), .TO_W(TOW)) i_ps2_host_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .start_i(start), .data_i(din),
    .timeout_i(tmo), .ps2_clk_i(clk_line), .ps2_data_i(data_line),
    .ps2_clk_oe_o(clk_oe), .ps2_data_oe_o(data_oe), .busy_o(busy),
    .done_o(done), .ack_ok_o(ack_ok), .err_o(err)
  );

  int n_run = 0, n_fail = 0, n_done = 0;
  logic [9:0] exp_q[$];      // {timeout, ack, byte}
  logic [7:0] cap_byte;
  logic       cap_par, cap_stop, cap_start;
  bit         finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model: measures request, then clocks the frame
  task automatic device(input bit ack, input bit early, input bit silent);
    int n = 0, o = 0;
    while (!clk_oe) @(negedge clk);
    while (clk_oe) begin
      n++;
      if (data_oe) o++;
      @(negedge clk);
    end
    chk(n == RTS, "R2 clock hold cycles", n, RTS);
    chk(o == LEAD, "R3 data lead cycles", o, LEAD);
    chk(data_oe == 1'b1, "R3 data low after release", data_oe, 1);
    if (silent) return;
    if (early) begin
      @(negedge clk); dev_clk = 1'b0;
      repeat (2) @(negedge clk); dev_clk = 1'b1;
    end
    repeat (GUARD + 6) @(negedge clk);
    for (int k = 1; k <= 11; k++) begin
      if (k == 1) cap_start = data_line;
      else if (k <= 9) cap_byte[k-2] = data_line;
      else if (k == 10) cap_par = data_line;
      else cap_stop = data_line;
      if (k == 11 && ack) dev_data = 1'b0;
      dev_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      dev_clk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    dev_data = 1'b1;
  endtask

  task automatic send(input logic [7:0] b, input bit ack, input bit early,
                      input bit silent, input bit poke);
    exp_q.push_back({silent, ack & ~silent, b});
    @(negedge clk);
    start = 1'b1; din = b;
    @(negedge clk);
    start = 1'b0; din = 8'h00;
    fork
      device(ack, early, silent);
      begin
        if (poke) begin
          repeat (60) @(negedge clk);
          start = 1'b1; din = ~b;
          @(negedge clk);
          start = 1'b0; din = 8'h00;
        end
      end
    join
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done && exp_q.size() != 0) begin
        logic [9:0] e;
        e = exp_q.pop_front();
        n_done++;
        chk(busy == 1'b0, "R9 busy low with done", busy, 0);
        chk(ack_ok == e[8], "R5 ack status", ack_ok, e[8]);
        chk(err == ~e[8], "R5 err status", err, ~e[8]);
        if (e[9]) begin
          chk(!clk_oe && !data_oe, "R7 lines released after timeout", {clk_oe, data_oe}, 0);
        end else begin
          chk(cap_start == 1'b0, "R3 start bit", cap_start, 0);
          chk(cap_byte == e[7:0], "R4 data bits lsb first", cap_byte, e[7:0]);
          chk(^{cap_byte, cap_par} == 1'b1, "R4 odd parity", cap_par, ~^cap_byte);
          chk(cap_stop == 1'b1, "R4 stop released", cap_stop, 1);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
      end else if (done) begin
        n_done++;
        chk(1'b0, "R6 unexpected done", 1, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!clk_oe && !data_oe, "R1 lines released in reset", {clk_oe, data_oe}, 0);
    chk(!busy && !done, "R1 idle in reset", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!clk_oe && !data_oe && !busy, "R1 idle after reset", {clk_oe, data_oe, busy}, 0);

    send(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0);   // R4 R5 ack
    send(8'h01, 1'b0, 1'b0, 1'b0, 1'b0);   // R5 no ack
    send(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);   // R4 parity with even ones
    send(8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    send(8'h3C, 1'b1, 1'b0, 1'b0, 1'b1);   // R6 start while busy
    send(8'h96, 1'b1, 1'b1, 1'b0, 1'b0);   // R8 early pulse in guard
    repeat (20) @(negedge clk);
    chk(ack_ok == 1'b1 && err == 1'b0, "R9 status held", {ack_ok, err}, 2);
    send(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0);   // R7 timeout
    repeat (20) @(negedge clk);
    chk(err == 1'b1, "R9 err held after timeout", err, 1);
    chk(!busy && !clk_oe && !data_oe, "R7 R1 idle after timeout", {busy, clk_oe, data_oe}, 0);
    chk(n_done == 7, "R6 done count", n_done, 7);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule